// File: doc/BRIEF.md
# Four-Phase Interlocked Word Link

This block pairs a word provider and a word consumer that share one clock and pass 4-bit words over a shared bus. Two control wires carry the handshake: a request from the consumer and a ready from the provider. Every transfer runs the full return-to-zero cycle: request rises, ready rises, the word is captured, request falls, ready falls. Neither side moves to its next phase until it has seen the other side's previous edge at a clock edge. Each side spends a parameterised number of cycles in its own quiet phase, standing in for preparation or processing time.

The provider takes the word from `word_in` at the moment it answers a request. It holds that word on `bus_word` while ready is high. The consumer waits a parameterised capture interval after it sees ready. It then latches the bus into `cap_word`, pulses `cap_valid` for one cycle and withdraws its request. It starts a new request only after ready has dropped and its own idle interval has run out. Interval parameters below 1 are treated as 1.

Top module: `hs_link`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `srv_rdy`, `cli_req`, `cap_valid`, `bus_word` and `cap_word` are all 0.
- R2: `srv_rdy` rises only on the clock edge after one at which `cli_req` was seen high. At that same edge `bus_word` takes the value of `word_in`.
- R3: Once high, `srv_rdy` stays high as long as `cli_req` is high. It falls on the first edge after an edge at which `cli_req` was seen low.
- R4: While `srv_rdy` is high, `bus_word` does not change, even if `word_in` changes.
- R5: `cap_valid` asserts CAP+1 cycles after `srv_rdy` rises, where CAP is the capture interval. In that same cycle `cap_word` equals the word on the bus and `cli_req` has fallen.
- R6: `cap_valid` is high for exactly one cycle per transfer.
- R7: After `cli_req` falls, it stays low until after `srv_rdy` has fallen. A new request never rises while `srv_rdy` is high.
- R8: The number of cycles from the `cap_valid` cycle to the next rise of `srv_rdy` is max(IDLE+3, PREP+2), where PREP is the provider preparation interval and IDLE is the consumer idle interval.
- R9: An interval parameter of 0 behaves exactly as 1. With all three intervals at 0, capture follows ready by 2 cycles and the next ready follows capture by 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 4 | Word the provider issues on its next serve |
| bus_word | output | 4 | Shared data bus driven by the provider |
| srv_rdy | output | 1 | Provider ready (acknowledge) |
| cli_req | output | 1 | Consumer request |
| cap_word | output | 4 | Last word latched by the consumer |
| cap_valid | output | 1 | One-cycle pulse when `cap_word` is updated |

## Verification
A state or timer fault in either machine shows first as a shift in cycle counts. The capture pulse drifts from the ready rise, or the gap from capture to the next ready moves off max(IDLE+3, PREP+2). Both are visible within one transfer. A provider that serves too early or releases ready early shows within a cycle as ready changing while request is in the wrong phase. A bus-load fault shows at the next capture as a word that differs from the one presented when ready rose. Two instances are exercised, one with distinct intervals where preparation dominates and one with all intervals at 0, where the idle path dominates.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int WORD_W = 4;

  typedef enum logic [1:0] {
    PV_PREP  = 2'd0,
    PV_WAIT  = 2'd1,
    PV_SERVE = 2'd2
  } prov_st_t;

  typedef enum logic [1:0] {
    CN_IDLE = 2'd0,
    CN_REQ  = 2'd1,
    CN_CAPT = 2'd2,
    CN_DONE = 2'd3
  } cons_st_t;
endpackage

// File: rtl/hs_interval.sv
module hs_interval #(
  parameter int LEN = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  localparam int EFF = (LEN < 1) ? 1 : LEN;
  localparam int CW  = (EFF > 1) ? $clog2(EFF) : 1;
  localparam logic [CW-1:0] START = CW'(EFF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || load) cnt <= START;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= START); // R9
endmodule

// File: rtl/hs_provider.sv
module hs_provider
  import hs_pkg::*;
#(
  parameter int DATA_W   = WORD_W,
  parameter int PREP_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] bus_o
);
  prov_st_t st;
  logic     prep_load;
  logic     prep_done;

  assign prep_load = (st == PV_SERVE) && !req_i;

  hs_interval #(.LEN(PREP_CYC)) u_prep (
    .clk  (clk),
    .rst  (rst),
    .load (prep_load),
    .done (prep_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= PV_PREP;
      rdy_o <= 1'b0;
      bus_o <= '0;
    end else begin
      unique case (st)
        PV_PREP: if (prep_done) st <= PV_WAIT;
        PV_WAIT: if (req_i) begin
          st    <= PV_SERVE;
          rdy_o <= 1'b1;
          bus_o <= word_i;
        end
        PV_SERVE: if (!req_i) begin
          st    <= PV_PREP;
          rdy_o <= 1'b0;
        end
        default: st <= PV_PREP;
      endcase
    end
  end

  AST_RDY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_o) |-> $past(req_i)); // R2
  AST_RDY_HELD: assert property (@(posedge clk) disable iff (rst)
    ($past(rdy_o) && $past(req_i)) |-> rdy_o); // R3
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (rdy_o && $past(rdy_o)) |-> $stable(bus_o)); // R4
endmodule

// File: rtl/hs_consumer.sv
module hs_consumer
  import hs_pkg::*;
#(
  parameter int DATA_W   = WORD_W,
  parameter int IDLE_CYC = 1,
  parameter int CAP_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdy_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              req_o,
  output logic [DATA_W-1:0] cap_o,
  output logic              cap_v_o
);
  cons_st_t st;
  logic     idle_load, idle_done;
  logic     cap_load, cap_done;

  assign idle_load = (st == CN_DONE) && !rdy_i;
  assign cap_load  = (st == CN_REQ) && rdy_i;

  hs_interval #(.LEN(IDLE_CYC)) u_idle (
    .clk  (clk),
    .rst  (rst),
    .load (idle_load),
    .done (idle_done)
  );

  hs_interval #(.LEN(CAP_CYC)) u_capt (
    .clk  (clk),
    .rst  (rst),
    .load (cap_load),
    .done (cap_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= CN_IDLE;
      req_o   <= 1'b0;
      cap_o   <= '0;
      cap_v_o <= 1'b0;
    end else begin
      cap_v_o <= 1'b0;
      unique case (st)
        CN_IDLE: if (idle_done) begin
          st    <= CN_REQ;
          req_o <= 1'b1;
        end
        CN_REQ: if (rdy_i) st <= CN_CAPT;
        CN_CAPT: if (cap_done) begin
          st      <= CN_DONE;
          req_o   <= 1'b0;
          cap_o   <= bus_i;
          cap_v_o <= 1'b1;
        end
        CN_DONE: if (!rdy_i) st <= CN_IDLE;
        default: st <= CN_IDLE;
      endcase
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cap_v_o |=> !cap_v_o); // R6
  AST_CAP_IN_SERVE: assert property (@(posedge clk) disable iff (rst)
    cap_v_o |-> rdy_i); // R5
  AST_REQ_DROP_AT_CAP: assert property (@(posedge clk) disable iff (rst)
    $fell(req_o) |-> cap_v_o); // R5
  AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> !rdy_i); // R7
endmodule

// File: rtl/hs_link.sv
module hs_link
  import hs_pkg::*;
#(
  parameter int DATA_W   = WORD_W,
  parameter int PREP_CYC = 5,
  parameter int IDLE_CYC = 1,
  parameter int CAP_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] bus_word,
  output logic              srv_rdy,
  output logic              cli_req,
  output logic [DATA_W-1:0] cap_word,
  output logic              cap_valid
);
  hs_provider #(
    .DATA_W   (DATA_W),
    .PREP_CYC (PREP_CYC)
  ) u_prov (
    .clk    (clk),
    .rst    (rst),
    .req_i  (cli_req),
    .word_i (word_in),
    .rdy_o  (srv_rdy),
    .bus_o  (bus_word)
  );

  hs_consumer #(
    .DATA_W   (DATA_W),
    .IDLE_CYC (IDLE_CYC),
    .CAP_CYC  (CAP_CYC)
  ) u_cons (
    .clk     (clk),
    .rst     (rst),
    .rdy_i   (srv_rdy),
    .bus_i   (bus_word),
    .req_o   (cli_req),
    .cap_o   (cap_word),
    .cap_v_o (cap_valid)
  );

  AST_RDY_FALL_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    $fell(srv_rdy) |-> $past(!cli_req)); // R3
endmodule

// File: tb/hs_link_bench.sv
module hs_link_bench;
  localparam int CLK_PERIOD = 10;

  localparam int P0 = 5, I0 = 1, C0 = 3;
  localparam int P1 = 0, I1 = 0, C1 = 0;

  logic       clk = 1'b0;
  logic       rst_v   [2];
  logic [3:0] win     [2];
  logic [3:0] bus_v   [2];
  logic       rdy_v   [2];
  logic       req_v   [2];
  logic [3:0] capw_v  [2];
  logic       capv_v  [2];

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int last_cap [2];
  bit have_prev [2];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hs_link #(.PREP_CYC(P0), .IDLE_CYC(I0), .CAP_CYC(C0)) u_hs_link (
    .clk(clk), .rst(rst_v[0]), .word_in(win[0]), .bus_word(bus_v[0]),
    .srv_rdy(rdy_v[0]), .cli_req(req_v[0]), .cap_word(capw_v[0]),
    .cap_valid(capv_v[0])
  );

  hs_link #(.PREP_CYC(P1), .IDLE_CYC(I1), .CAP_CYC(C1)) u_hs_link_min (
    .clk(clk), .rst(rst_v[1]), .word_in(win[1]), .bus_word(bus_v[1]),
    .srv_rdy(rdy_v[1]), .cli_req(req_v[1]), .cap_word(capw_v[1]),
    .cap_valid(capv_v[1])
  );

  function automatic int eff(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int gap_of(input int p, input int i);
    int a, b;
    a = eff(i) + 3;
    b = eff(p) + 2;
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input int idx);
    rst_v[idx] = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rdy_v[idx] && !req_v[idx] && !capv_v[idx], "R1 handshake low in reset",
        {rdy_v[idx], req_v[idx], capv_v[idx]}, 0);
    chk(bus_v[idx] == 0 && capw_v[idx] == 0, "R1 registers clear in reset",
        {bus_v[idx], capw_v[idx]}, 0);
    rst_v[idx] = 1'b0;
    @(negedge clk);
    chk(!rdy_v[idx] && !capv_v[idx], "R1 first cycle after reset",
        {rdy_v[idx], capv_v[idx]}, 0);
    have_prev[idx] = 1'b0;
  endtask

  task automatic xfer(input int idx, input logic [3:0] w, input int lat, input int gap);
    int t_rise;
    win[idx] = w;
    do @(negedge clk); while (!rdy_v[idx]);
    t_rise = cyc;
    chk(bus_v[idx] == w, "R2 bus loaded from word_in", bus_v[idx], w);
    chk(req_v[idx] == 1'b1, "R2 ready only under request", req_v[idx], 1);
    if (have_prev[idx])
      chk(t_rise - last_cap[idx] == gap, "R8 capture-to-ready gap",
          t_rise - last_cap[idx], gap);
    win[idx] = ~w;
    do begin
      @(negedge clk);
      if (rdy_v[idx])
        chk(bus_v[idx] == w, "R4 bus stable while ready", bus_v[idx], w);
    end while (!capv_v[idx]);
    chk(cyc - t_rise == lat, "R5 capture latency", cyc - t_rise, lat);
    chk(capw_v[idx] == w, "R5 captured word", capw_v[idx], w);
    chk(req_v[idx] == 1'b0, "R5 request dropped at capture", req_v[idx], 0);
    chk(rdy_v[idx] == 1'b1, "R3 ready held until request seen low", rdy_v[idx], 1);
    last_cap[idx] = cyc;
    have_prev[idx] = 1'b1;
    @(negedge clk);
    chk(capv_v[idx] == 1'b0, "R6 capture pulse one cycle", capv_v[idx], 0);
    chk(rdy_v[idx] == 1'b0, "R3 ready falls one cycle after request", rdy_v[idx], 1'b0);
    chk(req_v[idx] == 1'b0, "R7 no request before ready low", req_v[idx], 0);
  endtask

  task automatic run_main;
    logic [3:0] words [6] = '{4'hA, 4'h3, 4'hF, 4'h0, 4'h6, 4'h9};
    do_reset(0);
    for (int k = 0; k < 6; k++)
      xfer(0, words[k], eff(C0) + 1, gap_of(P0, I0));
  endtask

  task automatic run_min;
    logic [3:0] words [3] = '{4'h5, 4'hC, 4'h1};
    do_reset(1);
    for (int k = 0; k < 3; k++)
      xfer(1, words[k], 2, 4); // R9: zero intervals act as one
  endtask

  initial begin
    rst_v[0] = 1'b1; rst_v[1] = 1'b1;
    win[0] = '0; win[1] = '0;
    run_main();
    run_min();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule